// File: doc/BRIEF.md
# Port Interrupt Trigger Detector

The block watches the already-synchronized levels of one port of general-purpose pins and turns pin activity into interrupt status. Each pin has its own trigger mode: rising edge, falling edge, either edge, active-high level or active-low level. Software picks the mode through a single wide type register. When a pin meets its trigger condition, a sticky status bit is set. Software clears status bits by writing ones to a clear strobe.

A per-pin enable register masks the status. The port raises one interrupt line whenever any enabled status bit is set. Edges are found by comparing each pin with the value it had one clock earlier. After the type register is written, edge detection rests for one cycle, so that a change of mode cannot report an edge the new mode never saw.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted and right after it, status, enables and the interrupt line are all zero. The type register resets to zero, which means active-low level mode for every pin.
- R2: Type-register bit n is the polarity of pin n, bit n+NPINS selects edge mode and bit n+2*NPINS selects both edges. With only the polarity bit set (active-high level), status bit n is set on every cycle in which pin n is high.
- R3: With all three type bits of pin n clear (active-low level), status bit n is set on every cycle in which pin n is low.
- R4: With the edge bit and the polarity bit set (rising edge), status bit n is set after a low-to-high change of pin n and not after a high-to-low change.
- R5: With only the edge bit set (falling edge), status bit n is set after a high-to-low change and not after a low-to-high change.
- R6: With the edge bit and the both-edges bit set, every change of pin n sets status bit n.
- R7: A clear write with a one in bit n clears status bit n. Bits written as zero keep their value.
- R8: If a trigger and a clear reach the same status bit in the same cycle, the bit ends up set. A level-mode bit whose level is still active therefore cannot be cleared.
- R9: An edge that arrives after its status bit has been cleared sets the bit again.
- R10: The interrupt output is high exactly when some status bit has its enable bit set. Enables reset to zero and are loaded by an enable write.
- R11: In the clock cycle right after a type-register write, no edge event is recorded. The pin history is reloaded in that cycle, and edges are detected again from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl | input | NPINS | Synchronized pin levels |
| type_wr | input | 1 | Load strobe for the trigger type register |
| type_wdata | input | 3*NPINS | New type value: polarity, edge-select and both-edges fields |
| enable_wr | input | 1 | Load strobe for the enable register |
| enable_wdata | input | NPINS | New per-pin interrupt enables |
| clear_wr | input | 1 | Clear strobe |
| clear_wdata | input | NPINS | Write-one-to-clear mask for status |
| status | output | NPINS | Sticky per-pin status |
| irq | output | 1 | Port interrupt request |

## Verification
The embedded assertions check the following on every clock:
- Cleared bits drop and all other bits hold.
- A trigger always lands in status, even when a clear hits the same bit.
- The edge path stays silent in the cycle after a type write.
- The interrupt line stays low while the enables are zero.

Other behaviours only show up in the bench's scenarios: each trigger mode really responds to its own condition and ignores the opposite one, a re-armed edge is caught again after a clear, and a genuine edge that falls into the rest cycle is dropped while the next edge is caught. The bench also runs a behavioural model alongside the design and compares status and interrupt on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef struct packed {
    logic dual;
    logic edge_sel;
    logic pol;
  } trig_cfg_t;

  // Trigger condition for one pin in one cycle.
  function automatic logic trig_hit(input trig_cfg_t cfg, input logic cur,
                                    input logic prev, input logic hist_ok);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (!cfg.edge_sel) return (cur == cfg.pol);
    if (cfg.dual) return hist_ok & (rise | fall);
    return hist_ok & (cfg.pol ? rise : fall);
  endfunction

endpackage

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int TYPE_W = 3 * NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic [TYPE_W-1:0] type_q,
  input  logic              type_wr,
  output logic [NPINS-1:0]  hit,
  output logic [NPINS-1:0]  edge_hit
);

  logic [NPINS-1:0] prev_q;
  logic             hist_ok_q;

  // History of the pins; invalid for one cycle after reset or a type write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      hist_ok_q <= 1'b0;
    end else begin
      prev_q    <= pin_lvl;
      hist_ok_q <= ~type_wr;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    trig_cfg_t cfg;
    assign cfg.pol      = type_q[i];
    assign cfg.edge_sel = type_q[i + NPINS];
    assign cfg.dual     = type_q[i + 2*NPINS];
    assign hit[i]       = trig_hit(cfg, pin_lvl[i], prev_q[i], hist_ok_q);
    assign edge_hit[i]  = cfg.edge_sel & hit[i];
  end

  // R11: no edge event in the cycle after a type write
  a_r11_no_edge_after_type: assert property (@(posedge clk) disable iff (!rst_n)
    $past(type_wr) |-> (edge_hit == '0));

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_vec,
  input  logic [NPINS-1:0] clr_vec,
  output logic [NPINS-1:0] status
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end

  // R7: cleared bits without a coincident set drop to zero
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_vec & ~set_vec)) == '0));

  // R7: bits not cleared keep their value
  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~clr_vec)) == $past(status & ~clr_vec)));

  // R8: a trigger always lands, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int TYPE_W = 3 * NPINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic              type_wr,
  input  logic [TYPE_W-1:0] type_wdata,
  input  logic              enable_wr,
  input  logic [NPINS-1:0]  enable_wdata,
  input  logic              clear_wr,
  input  logic [NPINS-1:0]  clear_wdata,
  output logic [NPINS-1:0]  status,
  output logic              irq
);

  logic [TYPE_W-1:0] type_q;
  logic [NPINS-1:0]  en_q;
  logic [NPINS-1:0]  hit;
  logic [NPINS-1:0]  edge_hit;
  logic [NPINS-1:0]  clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      en_q   <= '0;
    end else begin
      if (type_wr)   type_q <= type_wdata;
      if (enable_wr) en_q   <= enable_wdata;
    end
  end

  assign clr_vec = clear_wr ? clear_wdata : '0;

  gpio_irq_trigger #(.NPINS(NPINS)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .type_q   (type_q),
    .type_wr  (type_wr),
    .hit      (hit),
    .edge_hit (edge_hit)
  );

  gpio_irq_status #(.NPINS(NPINS)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (hit),
    .clr_vec (clr_vec),
    .status  (status)
  );

  assign irq = |(status & en_q);

  // R10: no request while every enable is off
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R1: first cycle out of reset has empty status
  a_r1_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (status == '0));

endmodule

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;
  localparam int N = 8;
  localparam int TW = 3 * N;
  localparam int MAX_CYC = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]  pins = '1;
  logic          type_wr = 1'b0;
  logic [TW-1:0] type_wdata = '0;
  logic          enable_wr = 1'b0;
  logic [N-1:0]  enable_wdata = '0;
  logic          clear_wr = 1'b0;
  logic [N-1:0]  clear_wdata = '0;
  logic [N-1:0]  status;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  gpio_irq_port #(.NPINS(N)) u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pins),
    .type_wr(type_wr), .type_wdata(type_wdata),
    .enable_wr(enable_wr), .enable_wdata(enable_wdata),
    .clear_wr(clear_wr), .clear_wdata(clear_wdata),
    .status(status), .irq(irq)
  );

  // Behavioural reference model
  logic [TW-1:0] m_type;
  logic [N-1:0]  m_en, m_stat, m_prev;
  logic          m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_type = '0; m_en = '0; m_stat = '0; m_prev = '0; m_valid = 1'b0;
    end else begin
      logic [N-1:0] ev;
      for (int i = 0; i < N; i++) begin
        case ({m_type[2*N+i], m_type[N+i], m_type[i]})
          3'b000, 3'b100: ev[i] = (pins[i] == 1'b0);
          3'b001, 3'b101: ev[i] = (pins[i] == 1'b1);
          3'b011:         ev[i] = m_valid && pins[i] && !m_prev[i];
          3'b010:         ev[i] = m_valid && !pins[i] && m_prev[i];
          default:        ev[i] = m_valid && (pins[i] != m_prev[i]);
        endcase
      end
      if (clear_wr) m_stat = m_stat & ~clear_wdata;
      m_stat  = m_stat | ev;
      m_prev  = pins;
      m_valid = !type_wr;
      if (type_wr)   m_type = type_wdata;
      if (enable_wr) m_en   = enable_wdata;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (status !== m_stat || irq !== (|(m_stat & m_en))) begin
        errors++;
        $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                 cur_req, status, irq, m_stat, |(m_stat & m_en));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC) begin
      checks++; errors++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, MAX_CYC);
      report();
    end
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk_bit(input string req, input int idx, input logic exp);
    checks++;
    if (status[idx] !== exp) begin
      errors++;
      $display("FAIL %s: status[%0d]=%b expected %b", req, idx, status[idx], exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", req, irq, exp);
    end
  endtask

  task automatic do_clear(input logic [N-1:0] m);
    clear_wr = 1'b1; clear_wdata = m; tick(1);
    clear_wr = 1'b0; clear_wdata = '0;
  endtask

  task automatic do_type(input logic [TW-1:0] v);
    type_wr = 1'b1; type_wdata = v; tick(1);
    type_wr = 1'b0;
  endtask

  task automatic do_enable(input logic [N-1:0] v);
    enable_wr = 1'b1; enable_wdata = v; tick(1);
    enable_wr = 1'b0;
  endtask

  // pin0 rising, pin1 falling, pin2 both edges, pin3 level high, pins4-7 level low
  localparam logic [TW-1:0] TYPE_A = 24'h040709;
  localparam logic [TW-1:0] TYPE_B = 24'h042729;

  initial begin
    tick(3);
    cur_req = "R1";
    checks++;
    if (status !== '0 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1: status=%h irq=%b expected 00 0", status, irq);
    end
    rst_n = 1'b1;
    tick(1);
    chk_bit("R1", 0, 1'b0);

    cur_req = "R2";
    do_type(TYPE_A);
    tick(2);
    do_clear('1);
    tick(1);
    chk_bit("R2", 3, 1'b1);
    pins[3] = 1'b0; tick(2);
    do_clear(8'h08); tick(1);
    chk_bit("R2", 3, 1'b0);

    cur_req = "R4";
    pins[0] = 1'b0; tick(2);
    chk_bit("R4", 0, 1'b0);
    pins[0] = 1'b1; tick(2);
    chk_bit("R4", 0, 1'b1);

    cur_req = "R6";
    pins[2] = 1'b0; tick(2);
    chk_bit("R6", 2, 1'b1);
    cur_req = "R7";
    do_clear(8'h01); tick(1);
    chk_bit("R7", 0, 1'b0);
    chk_bit("R7", 2, 1'b1);
    cur_req = "R6";
    do_clear(8'h04); tick(1);
    chk_bit("R6", 2, 1'b0);
    pins[2] = 1'b1; tick(2);
    chk_bit("R6", 2, 1'b1);

    cur_req = "R5";
    pins[1] = 1'b0; tick(2);
    chk_bit("R5", 1, 1'b1);
    do_clear(8'h02);
    pins[1] = 1'b1; tick(2);
    chk_bit("R5", 1, 1'b0);

    cur_req = "R8";
    pins[0] = 1'b0; tick(2);
    pins[0] = 1'b1; clear_wr = 1'b1; clear_wdata = 8'h01; tick(1);
    clear_wr = 1'b0; clear_wdata = '0; tick(1);
    chk_bit("R8", 0, 1'b1);

    cur_req = "R9";
    do_clear(8'h01);
    chk_bit("R9", 0, 1'b0);
    pins[0] = 1'b0; tick(1);
    pins[0] = 1'b1; tick(2);
    chk_bit("R9", 0, 1'b1);

    cur_req = "R3";
    pins[4] = 1'b0; tick(2);
    chk_bit("R3", 4, 1'b1);
    cur_req = "R8";
    do_clear(8'h10); tick(1);
    chk_bit("R8", 4, 1'b1);
    cur_req = "R3";
    pins[4] = 1'b1; tick(1);
    do_clear(8'h10); tick(1);
    chk_bit("R3", 4, 1'b0);

    cur_req = "R10";
    chk_irq("R10", 1'b0);
    do_enable(8'h01); tick(1);
    chk_irq("R10", 1'b1);
    do_enable(8'h80); tick(1);
    chk_irq("R10", 1'b0);

    cur_req = "R11";
    pins[5] = 1'b0; tick(2);
    do_type(TYPE_B);
    pins[5] = 1'b1; tick(1);
    do_clear(8'h20); tick(1);
    chk_bit("R11", 5, 1'b0);
    pins[5] = 1'b0; tick(1);
    pins[5] = 1'b1; tick(2);
    chk_bit("R11", 5, 1'b1);

    tick(2);
    report();
  end
endmodule